// File: doc/BRIEF.md
# Coarse Frequency Lock Detector

This block tells the rest of a clocking subsystem whether a feedback clock runs close to its target rate, measured against a reference clock. It works entirely in the reference-clock domain. The feedback clock drives a free-running Gray-coded counter. That counter is carried into the reference domain through a two-flop synchronizer. Once per refresh period of 32 reference cycles, the block takes the difference between the counter value at the start and at the end of a 14-cycle measurement window. It saturates that count and uses it to update a lock flag with hysteresis.

Two enumerated state machines drive the block. The window machine has two states. It leaves `PH_REST` for `PH_OPEN` at phase 0 of each period, which captures the start sample. It returns from `PH_OPEN` to `PH_REST` at phase 14, which closes the window and evaluates the count. The lock machine also has two states. It moves from `ST_UNLOCKED` to `ST_LOCKED` at a window close whose count lies in the acquire range. It moves from `ST_LOCKED` to `ST_UNLOCKED` at a window close whose count lies outside the release range. Because the acquire range is narrower than the release range, a clock near the edge of the target band does not make the flag chatter. With no reference clock, nothing is evaluated, so the flag keeps its last value.

Top module: `coarse_lock_detect`

## Requirements
- R1: While `rst_n` is low, `lock_o` is 0 and `count_o` is 0.
- R2: `lock_o` and `count_o` change only on the reference edge at which the internal phase, counted from 0 at the first edge after reset and wrapping after 31, equals 14. Between such edges they hold, so one evaluation happens every 32 reference cycles.
- R3: The captured count equals the number of feedback rising edges in the 14 reference cycles between window open (phase 0) and window close (phase 14). It is within ±1 of 14 times the feedback/reference frequency ratio.
- R4: When the flag is low, it goes high at an evaluation only if the count is 13, 14 or 15. Otherwise it stays low. A count of 16 or 17 does not set it.
- R5: When the flag is high, it goes low at an evaluation only if the count is below 11 or above 17. Otherwise it stays high. A count of 11 or 12 does not clear it.
- R6: A window with 31 or more feedback edges reports `count_o` = 31. That value lies outside both ranges, so it clears a high flag and never sets a low one.
- R7: If the reference clock stops, `lock_o` and `count_o` keep their values for as long as it stays stopped, whatever the feedback clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all evaluation logic runs on its rising edge |
| fb_clk | input | 1 | Feedback clock whose rising edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lock_o | output | 1 | Coarse lock flag, 1 = feedback rate inside the band |
| count_o | output | 5 | Feedback edge count captured at the last window close, saturated at 31 |

## Verification
The bench steps the feedback clock through ratios of 0.7, 0.8, 0.9, 1.0, 1.1, 1.2 and 1.3, plus a very fast clock. The ratios 0.8 and 1.2 give counts of 11–12 and 16–17. A design that used a single range instead of two would drop lock on those counts from the locked state, or acquire on them from the unlocked state. The very fast clock catches a counter that wraps instead of saturating: such a counter would report a small count that looks legal, and could keep or even take lock. Outputs are checked one cycle before each evaluation to catch updates on the wrong phase. The reference clock is then held low while the feedback clock runs out of band. A design that evaluated on the feedback clock, or reset the flag on a missing reference, would drop the flag during that time.

// File: rtl/coarse_lock_pkg.sv
package coarse_lock_pkg;

    typedef enum logic {
        PH_REST = 1'b0,
        PH_OPEN = 1'b1
    } win_phase_t;

    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_t;

endpackage

// File: rtl/fb_gray_counter.sv
module fb_gray_counter #(
    parameter int GW = 8
) (
    input  logic          fb_clk,
    input  logic          rst_n,
    output logic [GW-1:0] gray_o
);
    logic [GW-1:0] bin_q;
    logic [GW-1:0] bin_nx;

    assign bin_nx = bin_q + GW'(1);

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/gray_ref_sync.sv
module gray_ref_sync #(
    parameter int GW = 8
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [GW-1:0] gray_i,
    output logic [GW-1:0] bin_o
);
    logic [GW-1:0] meta_q;
    logic [GW-1:0] sync_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_i;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_o[GW-1] = sync_q[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/lock_evaluator.sv
module lock_evaluator
    import coarse_lock_pkg::*;
#(
    parameter int PERIOD = 32,
    parameter int WINDOW = 14,
    parameter int GW     = 8,
    parameter int CNT_W  = 5,
    parameter int ACQ_LO = 13,
    parameter int ACQ_HI = 15,
    parameter int REL_LO = 11,
    parameter int REL_HI = 17
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [GW-1:0]    fb_count_i,
    output logic             lock_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PW = $clog2(PERIOD);
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam logic [PW-1:0]    LAST_PH  = PW'(PERIOD - 1);
    localparam logic [PW-1:0]    CLOSE_PH = PW'(WINDOW);
    localparam logic [GW-1:0]    SAT_G    = GW'(CNT_MAX);
    localparam logic [CNT_W-1:0] SAT_C    = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] ACQ_LO_C = CNT_W'(ACQ_LO);
    localparam logic [CNT_W-1:0] ACQ_HI_C = CNT_W'(ACQ_HI);
    localparam logic [CNT_W-1:0] REL_LO_C = CNT_W'(REL_LO);
    localparam logic [CNT_W-1:0] REL_HI_C = CNT_W'(REL_HI);

    logic [PW-1:0]    phase_q;
    logic [GW-1:0]    start_q;
    logic [GW-1:0]    span;
    logic [CNT_W-1:0] sat_cnt;
    logic [CNT_W-1:0] count_q;
    logic             open_ev;
    logic             close_ev;
    logic             in_acquire;
    logic             out_release;
    win_phase_t       win_q, win_d;
    lock_state_t      lock_q, lock_d;

    // Period phase counter
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + PW'(1);
    end

    assign open_ev  = (win_q == PH_REST) && (phase_q == '0);
    assign close_ev = (win_q == PH_OPEN) && (phase_q == CLOSE_PH);

    // Window length measurement with saturation
    assign span    = fb_count_i - start_q;
    assign sat_cnt = (span >= SAT_G) ? SAT_C : span[CNT_W-1:0];

    assign in_acquire  = (sat_cnt != SAT_C) && (sat_cnt >= ACQ_LO_C)
                         && (sat_cnt <= ACQ_HI_C);
    assign out_release = (sat_cnt == SAT_C) || (sat_cnt < REL_LO_C)
                         || (sat_cnt > REL_HI_C);

    // Next-state logic for both machines
    always_comb begin
        win_d = win_q;
        unique case (win_q)
            PH_REST: if (open_ev)  win_d = PH_OPEN;
            PH_OPEN: if (close_ev) win_d = PH_REST;
        endcase

        lock_d = lock_q;
        unique case (lock_q)
            ST_UNLOCKED: if (close_ev && in_acquire)  lock_d = ST_LOCKED;
            ST_LOCKED:   if (close_ev && out_release) lock_d = ST_UNLOCKED;
        endcase
    end

    // State and capture registers
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= PH_REST;
            lock_q  <= ST_UNLOCKED;
            start_q <= '0;
            count_q <= '0;
        end else begin
            win_q  <= win_d;
            lock_q <= lock_d;
            if (open_ev)  start_q <= fb_count_i;
            if (close_ev) count_q <= sat_cnt;
        end
    end

    // Outputs
    always_comb begin
        lock_o  = (lock_q == ST_LOCKED);
        count_o = count_q;
    end
endmodule

// File: rtl/coarse_lock_detect.sv
module coarse_lock_detect #(
    parameter int PERIOD = 32,
    parameter int WINDOW = 14,
    parameter int GW     = 8,
    parameter int CNT_W  = 5,
    parameter int ACQ_LO = 13,
    parameter int ACQ_HI = 15,
    parameter int REL_LO = 11,
    parameter int REL_HI = 17
) (
    input  logic             ref_clk,
    input  logic             fb_clk,
    input  logic             rst_n,
    output logic             lock_o,
    output logic [CNT_W-1:0] count_o
);
    logic [GW-1:0] fb_gray;
    logic [GW-1:0] fb_count;

    fb_gray_counter #(.GW(GW)) u_fbcnt (
        .fb_clk (fb_clk),
        .rst_n  (rst_n),
        .gray_o (fb_gray)
    );

    gray_ref_sync #(.GW(GW)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (fb_gray),
        .bin_o   (fb_count)
    );

    lock_evaluator #(
        .PERIOD (PERIOD),
        .WINDOW (WINDOW),
        .GW     (GW),
        .CNT_W  (CNT_W),
        .ACQ_LO (ACQ_LO),
        .ACQ_HI (ACQ_HI),
        .REL_LO (REL_LO),
        .REL_HI (REL_HI)
    ) u_eval (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .fb_count_i (fb_count),
        .lock_o     (lock_o),
        .count_o    (count_o)
    );
endmodule

// File: rtl/coarse_lock_checker.sv
module coarse_lock_checker #(
    parameter int PERIOD = 32,
    parameter int WINDOW = 14,
    parameter int CNT_W  = 5,
    parameter int ACQ_LO = 13,
    parameter int ACQ_HI = 15,
    parameter int REL_LO = 11,
    parameter int REL_HI = 17
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             lock_o,
    input logic [CNT_W-1:0] count_o
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    int unsigned tick;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tick <= 0;
        else        tick <= (tick == PERIOD - 1) ? 0 : tick + 1;
    end

    // R1
    reset_state_chk: assert property (@(posedge ref_clk)
        !rst_n |-> (!lock_o && count_o == '0));

    // R2
    hold_between_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (tick != WINDOW) |=> ($stable(lock_o) && $stable(count_o)));

    // R4
    acquire_range_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_o) |-> (int'(count_o) >= ACQ_LO && int'(count_o) <= ACQ_HI));

    // R4
    stay_low_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!$past(lock_o) && !(int'(count_o) >= ACQ_LO && int'(count_o) <= ACQ_HI))
        |-> !lock_o);

    // R5
    release_range_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lock_o) |-> (int'(count_o) < REL_LO || int'(count_o) > REL_HI));

    // R6
    sat_not_locked_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (int'(count_o) == CNT_MAX && $changed(count_o)) |-> !lock_o);
endmodule

bind coarse_lock_detect coarse_lock_checker #(
    .PERIOD (PERIOD),
    .WINDOW (WINDOW),
    .CNT_W  (CNT_W),
    .ACQ_LO (ACQ_LO),
    .ACQ_HI (ACQ_HI),
    .REL_LO (REL_LO),
    .REL_HI (REL_HI)
) i_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .lock_o  (lock_o),
    .count_o (count_o)
);

// File: tb/test_coarse_lock_detect.sv
`timescale 1ns/1ps
module test_coarse_lock_detect;
    logic       ref_clk = 1'b0;
    logic       fb_clk  = 1'b0;
    logic       rst_n   = 1'b0;
    logic       lock_o;
    logic [4:0] count_o;

    bit  ref_run = 1'b1;
    real fb_half = 2.5;
    int  total = 0;
    int  bad = 0;
    int  k = 0;
    bit  exp_lock = 1'b0;

    coarse_lock_detect i_coarse_lock_detect (
        .ref_clk (ref_clk),
        .fb_clk  (fb_clk),
        .rst_n   (rst_n),
        .lock_o  (lock_o),
        .count_o (count_o)
    );

    always #2.5 if (ref_run) ref_clk = ~ref_clk;

    initial begin
        #1.3;
        forever #(fb_half) fb_clk = ~fb_clk;
    end

    // bench-side period phase, mirrors the R2 schedule
    always @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) k <= 0;
        else        k <= (k == 31) ? 0 : k + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic wait_phase(input int ph);
        do @(posedge ref_clk); while (k != ph);
        #1;
    endtask

    // one evaluation: rule check on the flag, optional count range check
    task automatic evaluate(input bit check_range);
        int  c;
        real n;
        int  lo, hi;
        logic       l_now;
        logic [4:0] c_now;
        wait_phase(14);
        c = int'(count_o);
        if (exp_lock) exp_lock = !(c < 11 || c > 17 || c == 31);
        else          exp_lock = (c >= 13 && c <= 15);
        chk(lock_o == exp_lock, "R4/R5 flag rule", int'(lock_o), int'(exp_lock));
        if (check_range) begin
            n  = 70.0 / (2.0 * fb_half);
            lo = int'($floor(n));
            hi = int'($ceil(n));
            if (lo > 31) lo = 31;
            if (hi > 31) hi = 31;
            chk(c >= lo && c <= hi, "R3 window count", c, lo);
        end
        l_now = lock_o;
        c_now = count_o;
        wait_phase(13);
        chk(lock_o == l_now && count_o == c_now, "R2 hold until next eval",
            int'(count_o), int'(c_now));
    endtask

    task automatic run_ratio(input real ratio, input int evals);
        fb_half = 2.5 / ratio;
        evaluate(1'b0);
        evaluate(1'b0);
        for (int i = 0; i < evals; i++) evaluate(1'b1);
    endtask

    initial begin
        #12;
        chk(lock_o == 1'b0, "R1 lock in reset", int'(lock_o), 0);
        chk(count_o == 5'd0, "R1 count in reset", int'(count_o), 0);
        #10.2;
        rst_n = 1'b1;

        run_ratio(1.0, 3);
        chk(lock_o == 1'b1, "R4 acquire at ratio 1.0", int'(lock_o), 1);
        run_ratio(1.1, 3);
        chk(lock_o == 1'b1, "R5 hold at ratio 1.1", int'(lock_o), 1);
        run_ratio(1.2, 3);
        chk(lock_o == 1'b1, "R5 hold at ratio 1.2 (count 16/17)", int'(lock_o), 1);
        run_ratio(0.8, 3);
        chk(lock_o == 1'b1, "R5 hold at ratio 0.8 (count 11/12)", int'(lock_o), 1);
        run_ratio(1.3, 3);
        chk(lock_o == 1'b0, "R5 release at ratio 1.3", int'(lock_o), 0);
        run_ratio(1.2, 3);
        chk(lock_o == 1'b0, "R4 no acquire at ratio 1.2", int'(lock_o), 0);
        run_ratio(0.8, 3);
        chk(lock_o == 1'b0, "R4 no acquire at ratio 0.8", int'(lock_o), 0);
        run_ratio(0.9, 3);
        run_ratio(0.7, 3);
        chk(lock_o == 1'b0, "R5 low at ratio 0.7", int'(lock_o), 0);
        run_ratio(1.0, 2);
        chk(lock_o == 1'b1, "R4 reacquire at ratio 1.0", int'(lock_o), 1);

        // saturation: 70 feedback edges per window
        run_ratio(5.0, 2);
        chk(count_o == 5'd31, "R6 saturated count", int'(count_o), 31);
        chk(lock_o == 1'b0, "R6 saturation releases", int'(lock_o), 0);
        run_ratio(1.0, 2);
        chk(lock_o == 1'b1, "R6 reacquire after saturation", int'(lock_o), 1);

        // reference clock lost while locked
        @(negedge ref_clk);
        ref_run = 1'b0;
        fb_half = 2.5 / 1.3;
        for (int i = 0; i < 6; i++) begin
            #300;
            chk(lock_o == 1'b1, "R7 flag frozen without reference", int'(lock_o), 1);
            chk(count_o == 5'd14, "R7 count frozen without reference", int'(count_o), 14);
        end
        ref_run = 1'b1;
        evaluate(1'b0);
        evaluate(1'b0);
        evaluate(1'b1);
        chk(lock_o == 1'b0, "R5 release after reference returns", int'(lock_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule